// File: doc/BRIEF.md
# System Exception Status Unit

This block gathers synchronous exception events raised inside a processor core: stack overflow, illegal instruction, divide-by-zero and divide overflow. Each cause owns one sticky status bit. When an event arrives from a cause whose bit is clear, the bit is set and a single exception request goes to the CPU. The request carries the one vector address that every cause shares. Further events from a cause whose bit is still set are swallowed, so a repeating fault cannot stack more than one state push. Software clears a bit by writing 1 to it.

The exception request is a valid/ready stream toward the CPU. `exc_valid_o` rises one clock after an accepted event and stays high, with a steady vector, until the CPU raises `exc_ready_i`. A cycle in which both are high retires the request. Several causes accepted before the retirement merge into one request. A cause accepted in the retiring cycle itself raises a fresh request on the next cycle. No enable gates the request: exceptions are never subject to the global interrupt mask. A priority override output tells the neighbouring maskable-interrupt controller to stand aside while a request is outstanding.

The bit order of the cause vector is fixed: bit 0 stack overflow, bit 1 illegal instruction, bit 2 divide-by-zero, bit 3 divide overflow.

Top module: `sxc_unit`

## Requirements
- R1: After reset, `status_o` is 0, and `exc_valid_o` and `prio_override_o` are low.
- R2: An event on a cause whose status bit is clear sets that bit and raises `exc_valid_o` on the clock edge that samples the event.
- R3: While `exc_valid_o` is high, `exc_vec_o` equals the shared vector address 0x000008.
- R4: While `exc_valid_o` is high and `exc_ready_i` is low, the request and the vector stay unchanged. `exc_valid_o` falls after the edge where both are high, unless R12 applies.
- R5: An event on a cause whose bit is set, and not being cleared in that cycle, raises no request and leaves `status_o` unchanged.
- R6: Repeated illegal-instruction events (bit 1) yield exactly one request until bit 1 is cleared. The next event after the clear yields a new request.
- R7: A cycle with `clr_valid_i` high clears every status bit with a 1 in `clr_mask_i`. Bits with a 0 in the mask keep their value.
- R8: An event from a different cause, arriving after an earlier exception was acknowledged but while its bit is still set, raises a new request and sets its own bit. The earlier bit is kept.
- R9: Several causes firing in the same cycle set all their bits and form one request, which a single handshake retires.
- R10: An event in the same cycle as a write-1 clear of its own bit leaves the bit set and raises a new request.
- R11: `prio_override_o` is high exactly when `exc_valid_o` is high.
- R12: A cause accepted in the same cycle that a handshake retires the request keeps `exc_valid_o` high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_CAUSES | Per-cause single-cycle exception event |
| clr_valid_i | input | 1 | Status write strobe (write-1-to-clear) |
| clr_mask_i | input | NUM_CAUSES | Bits to clear when the strobe is high |
| exc_ready_i | input | 1 | CPU accepts the exception request |
| exc_valid_o | output | 1 | Exception request pending |
| exc_vec_o | output | ADDR_W | Shared exception vector address |
| status_o | output | NUM_CAUSES | Sticky per-cause status bits |
| prio_override_o | output | 1 | Tells the interrupt controller to yield |

## Verification
The bench drives an event in the same cycle as a clear of that bit. A design that lets the clear win would lose the exception and leave `exc_valid_o` low. It accepts a second cause in the exact cycle the CPU acknowledges the first. A design that lets the handshake drop the pending flag would lose the new request. It repeats illegal-instruction events while bit 1 is set, which would expose a design that pushes state again. It fires three causes at once, which would expose a design that needs one handshake per cause. It also holds back-pressure for several cycles and checks that the vector stays fixed and that the request does not drop early.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
  localparam int DEF_NUM_CAUSES = 4;
  localparam int DEF_ADDR_W     = 24;
  localparam int DEF_VEC_ADDR   = 'h000008;

  // Fixed cause positions in the status vector
  localparam int CAUSE_STACK_OVF  = 0;
  localparam int CAUSE_ILLEGAL    = 1;
  localparam int CAUSE_DIV_ZERO   = 2;
  localparam int CAUSE_DIV_OVF    = 3;
endpackage

// File: rtl/sxc_cause_bit.sv
// One sticky status flop. An event is accepted only when the bit is
// not already holding, where a same-cycle clear releases the hold.
module sxc_cause_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic set_o,
  output logic accept_o
);
  logic held;
  logic set_q;

  always_comb begin
    held     = set_q & ~clr_i;
    accept_o = evt_i & ~held;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) set_q <= 1'b0;
    else        set_q <= held | evt_i;
  end

  assign set_o = set_q;
endmodule

// File: rtl/sxc_req_ctrl.sv
// Pending-request flag for the valid/ready exception stream.
// New acceptances merge into an outstanding request; an acceptance in
// the retiring cycle keeps the request alive.
module sxc_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic any_accept_i,
  input  logic ready_i,
  output logic valid_o
);
  logic valid_q;
  logic valid_d;

  always_comb begin
    valid_d = any_accept_i | (valid_q & ~ready_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/sxc_unit.sv
module sxc_unit #(
  parameter int NUM_CAUSES = sxc_pkg::DEF_NUM_CAUSES,
  parameter int ADDR_W     = sxc_pkg::DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] VEC_ADDR = ADDR_W'(sxc_pkg::DEF_VEC_ADDR)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CAUSES-1:0] evt_i,
  input  logic                  clr_valid_i,
  input  logic [NUM_CAUSES-1:0] clr_mask_i,
  input  logic                  exc_ready_i,
  output logic                  exc_valid_o,
  output logic [ADDR_W-1:0]     exc_vec_o,
  output logic [NUM_CAUSES-1:0] status_o,
  output logic                  prio_override_o
);
  logic [NUM_CAUSES-1:0] clr_eff;
  logic [NUM_CAUSES-1:0] accept;
  logic                  any_accept;
  logic                  pend;

  assign clr_eff = clr_valid_i ? clr_mask_i : '0;

  for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_cause
    sxc_cause_bit u_bit (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt_i[g]),
      .clr_i    (clr_eff[g]),
      .set_o    (status_o[g]),
      .accept_o (accept[g])
    );
  end

  assign any_accept = |accept;

  sxc_req_ctrl u_req (
    .clk          (clk),
    .rst_n        (rst_n),
    .any_accept_i (any_accept),
    .ready_i      (exc_ready_i),
    .valid_o      (pend)
  );

  assign exc_valid_o     = pend;
  assign prio_override_o = pend;
  assign exc_vec_o       = pend ? VEC_ADDR : '0;
endmodule

// File: rtl/sxc_unit_chk.sv
module sxc_unit_chk #(
  parameter int NUM_CAUSES = 4,
  parameter int ADDR_W     = 24,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 'h8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_CAUSES-1:0] evt_i,
  input logic                  clr_valid_i,
  input logic [NUM_CAUSES-1:0] clr_mask_i,
  input logic                  exc_ready_i,
  input logic                  exc_valid_o,
  input logic [ADDR_W-1:0]     exc_vec_o,
  input logic [NUM_CAUSES-1:0] status_o,
  input logic                  prio_override_o
);
  logic [NUM_CAUSES-1:0] wmask;
  logic [NUM_CAUSES-1:0] fresh;
  assign wmask = clr_valid_i ? clr_mask_i : '0;
  assign fresh = evt_i & ~(status_o & ~wmask);

  AST_NEW_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fresh != '0) |=> exc_valid_o); // R2
  AST_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((status_o & $past(evt_i)) == $past(evt_i))); // R10
  AST_VEC_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_o |-> (exc_vec_o == VEC_ADDR)); // R3
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_o && !exc_ready_i) |=> (exc_valid_o && $stable(exc_vec_o))); // R4
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid_o && fresh == '0) |=> !exc_valid_o); // R5
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid_i && ((clr_mask_i & ~evt_i) != '0))
      |=> ((status_o & $past(clr_mask_i & ~evt_i)) == '0)); // R7
  AST_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    prio_override_o == exc_valid_o); // R11
  AST_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_o && exc_ready_i && fresh == '0) |=> !exc_valid_o); // R12
endmodule

bind sxc_unit sxc_unit_chk #(
  .NUM_CAUSES (NUM_CAUSES),
  .ADDR_W     (ADDR_W),
  .VEC_ADDR   (VEC_ADDR)
) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .evt_i           (evt_i),
  .clr_valid_i     (clr_valid_i),
  .clr_mask_i      (clr_mask_i),
  .exc_ready_i     (exc_ready_i),
  .exc_valid_o     (exc_valid_o),
  .exc_vec_o       (exc_vec_o),
  .status_o        (status_o),
  .prio_override_o (prio_override_o)
);

// File: tb/sxc_unit_tb_top.sv
module sxc_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 24;
  localparam logic [AW-1:0] VEC = 24'h000008;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt_i = '0;
  logic          clr_valid_i = 1'b0;
  logic [N-1:0]  clr_mask_i = '0;
  logic          exc_ready_i = 1'b0;
  logic          exc_valid_o;
  logic [AW-1:0] exc_vec_o;
  logic [N-1:0]  status_o;
  logic          prio_override_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sxc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_valid_i(clr_valid_i),
    .clr_mask_i(clr_mask_i), .exc_ready_i(exc_ready_i),
    .exc_valid_o(exc_valid_o), .exc_vec_o(exc_vec_o),
    .status_o(status_o), .prio_override_o(prio_override_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end at a negative edge with inputs idle.
  task automatic pulse(logic [N-1:0] m);
    evt_i = m;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic ack();
    exc_ready_i = 1'b1;
    @(negedge clk);
    exc_ready_i = 1'b0;
  endtask

  task automatic w1c(logic [N-1:0] m);
    clr_valid_i = 1'b1;
    clr_mask_i  = m;
    @(negedge clk);
    clr_valid_i = 1'b0;
    clr_mask_i  = '0;
  endtask

  task automatic t_reset();
    chk("R1 status", 32'(status_o), 0);
    chk("R1 valid", 32'(exc_valid_o), 0);
    chk("R1 override", 32'(prio_override_o), 0);
  endtask

  task automatic t_basic();
    pulse(4'b0100);
    chk("R2 status", 32'(status_o), 4'b0100);
    chk("R2 valid", 32'(exc_valid_o), 1);
    chk("R3 vector", 32'(exc_vec_o), 32'(VEC));
    chk("R11 override", 32'(prio_override_o), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 held valid", 32'(exc_valid_o), 1);
      chk("R4 held vector", 32'(exc_vec_o), 32'(VEC));
    end
    ack();
    chk("R4 retired", 32'(exc_valid_o), 0);
    chk("R11 override low", 32'(prio_override_o), 0);
    w1c(4'b0100);
    chk("R7 cleared", 32'(status_o), 0);
  endtask

  task automatic t_blocked();
    pulse(4'b0001);
    ack();
    pulse(4'b0001);
    chk("R5 no request", 32'(exc_valid_o), 0);
    chk("R5 status kept", 32'(status_o), 4'b0001);
    w1c(4'b0001);
  endtask

  task automatic t_illegal();
    pulse(4'b0010);
    chk("R6 first request", 32'(exc_valid_o), 1);
    ack();
    for (int i = 0; i < 3; i++) begin
      pulse(4'b0010);
      chk("R6 repeat blocked", 32'(exc_valid_o), 0);
    end
    w1c(4'b0010);
    pulse(4'b0010);
    chk("R6 after clear", 32'(exc_valid_o), 1);
    ack();
    w1c(4'b0010);
  endtask

  task automatic t_nested();
    pulse(4'b1000);
    ack();
    pulse(4'b0100);
    chk("R8 new request", 32'(exc_valid_o), 1);
    chk("R8 both bits", 32'(status_o), 4'b1100);
    ack();
    w1c(4'b1100);
  endtask

  task automatic t_multi();
    pulse(4'b1101);
    chk("R9 all bits", 32'(status_o), 4'b1101);
    chk("R9 valid", 32'(exc_valid_o), 1);
    ack();
    chk("R9 single handshake", 32'(exc_valid_o), 0);
    w1c(4'b0101);
    chk("R7 partial clear", 32'(status_o), 4'b1000);
    w1c(4'b1000);
    chk("R7 rest clear", 32'(status_o), 0);
  endtask

  task automatic t_clr_collide();
    pulse(4'b0001);
    ack();
    evt_i = 4'b0001;
    clr_valid_i = 1'b1;
    clr_mask_i = 4'b0001;
    @(negedge clk);
    evt_i = '0;
    clr_valid_i = 1'b0;
    clr_mask_i = '0;
    chk("R10 bit stays", 32'(status_o), 4'b0001);
    chk("R10 new request", 32'(exc_valid_o), 1);
    ack();
    w1c(4'b0001);
  endtask

  task automatic t_ack_collide();
    pulse(4'b0001);
    exc_ready_i = 1'b1;
    evt_i = 4'b0010;
    @(negedge clk);
    exc_ready_i = 1'b0;
    evt_i = '0;
    chk("R12 request kept", 32'(exc_valid_o), 1);
    chk("R12 status", 32'(status_o), 4'b0011);
    ack();
    chk("R12 retired", 32'(exc_valid_o), 0);
    w1c(4'b0011);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_blocked();
    t_illegal();
    t_nested();
    t_multi();
    t_clr_collide();
    t_ack_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule